// File: doc/BRIEF.md
# Redundant Reference Clock Switch

This block sits in front of a clock fan-out and forwards one of two reference clocks, a CMOS-level clock and a crystal-oscillator clock, both nominally 13 MHz, to a single output. A static strap input names the primary source. The other input is the standby. While the primary toggles, the output follows it. When the primary stops, the block moves the output to the standby on its own, and no runt pulse appears on the output.

Each input watches the other. A small toggle synchronizer in one clock domain sees the other clock's edges. A short timeout, counted in cycles of the watching clock, declares the silent clock lost. When the primary comes back, the block counts its cycles. The output returns to the primary only after a fixed number of clean cycles. If the primary drops out again before that number is reached, the count starts again from zero.

The hand-over uses two enable gates, one per clock. Each gate opens and closes only on the falling edge of its own clock, and it may open only after it has seen the other gate closed. A gate whose clock has died cannot close by itself, so the loss flag clears it asynchronously. A status pin shows which gate is open. The block has no data stream, so every pin is a plain level.

Top module: `refclk_failover`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low and `active_sel` is 0.
- R2: `prim_sel` = 1 makes `clk_xo` the primary and `prim_sel` = 0 makes `clk_cmos` the primary. Shortly after reset, with both inputs running, `clk_out` shows one rising edge for each rising edge of the primary (within one edge over a 40-cycle window).
- R3: If the input in use stops, stuck either high or low, the output moves to the other input within 20 cycles of the surviving input. From then on it follows that input edge for edge.
- R4: `clk_out` never shows a high or low phase shorter than the shorter half-period of the two inputs. The two enable gates are never open together.
- R5: Once the lost primary toggles again, the output stays on the standby for at least HOLD_CYC (default 1024) primary rising edges. It moves back to the primary within HOLD_CYC + 36 primary rising edges.
- R6: If the primary is lost again before its holdoff count finishes, the count restarts from zero when it returns. The partial run before the second loss does not shorten the wait.
- R7: Loss of the standby input while the primary is in use changes neither `active_sel` nor the edges on `clk_out`.
- R8: `active_sel` is 1 exactly while the `clk_xo` gate is open, and 0 otherwise (the `clk_cmos` gate open, or both gates shut during a hand-over).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cmos | input | 1 | CMOS-level reference clock; primary when `prim_sel` = 0 |
| clk_xo | input | 1 | Oscillator reference clock; primary when `prim_sel` = 1 |
| prim_sel | input | 1 | Static strap naming the primary input (1 = `clk_xo`, 0 = `clk_cmos`) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Gated, selected reference clock |
| active_sel | output | 1 | 1 while `clk_xo` drives the output, 0 otherwise |

## Verification
Two functions can meet in the same window: the holdoff count that leads back to the primary, and a fresh loss of that same primary. The bench runs the returning primary for 600 cycles, stops it, restarts it, and checks that the output is still on the standby 900 cycles later. It then checks that the output returns only after a full 1024-cycle run. A second meeting point is the forced shutdown of a gate stuck high, which falls in the same window as the standby gate opening. A pulse-width monitor on `clk_out` judges that hand-over. A per-cycle model of the expected source judges `active_sel`.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {SRC_CMOS = 1'b0, SRC_XO = 1'b1} src_e;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rcs_watch.sv
module rcs_watch #(
  parameter int unsigned LOSS_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic peer_tog,
  output logic lost
);
  localparam int unsigned LW = $clog2(LOSS_CYC + 1);
  localparam logic [LW-1:0] LIMIT = LW'(LOSS_CYC);

  logic          tog_s;
  logic          tog_prev;
  logic          seen;
  logic [LW-1:0] quiet;

  rcs_sync #(.W(1), .RST_VAL(1'b0)) u_tsync (
    .clk (clk),
    .arst(!rst_n),
    .d   (peer_tog),
    .q   (tog_s)
  );

  assign seen = tog_s ^ tog_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_prev <= 1'b0;
      quiet    <= '0;
    end else begin
      tog_prev <= tog_s;
      if (seen)
        quiet <= '0;
      else if (quiet != LIMIT)
        quiet <= quiet + 1'b1;
    end
  end

  assign lost = (quiet == LIMIT);

  // R3: any observed peer edge withdraws the loss flag on the next cycle
  p_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> !lost);
endmodule

// File: rtl/rcs_lane.sv
module rcs_lane #(
  parameter int unsigned HOLD_CYC = 1024,
  parameter int unsigned LOSS_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_prim,
  input  logic peer_tog,
  input  logic self_lost,
  input  logic peer_good,
  input  logic peer_gate,
  output logic own_tog,
  output logic peer_lost,
  output logic own_good,
  output logic gate_en
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  logic          arst;
  logic [1:0]    hold;
  logic          held;
  logic [CW-1:0] run_cnt;
  logic          peer_good_s;
  logic          peer_gate_s;
  logic          req;
  logic          stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_tog <= 1'b0;
    else        own_tog <= ~own_tog;
  end

  rcs_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .peer_tog(peer_tog),
    .lost    (peer_lost)
  );

  // loss of this lane's own clock forces the hold chain and gate shut
  assign arst = !rst_n || self_lost;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) hold <= {2{rst_n}};
    else      hold <= {hold[0], 1'b0};
  end
  assign held = hold[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= FULL;
    else if (held)
      run_cnt <= '0;
    else if (run_cnt != FULL)
      run_cnt <= run_cnt + 1'b1;
  end

  assign own_good = (run_cnt == FULL) && !held;

  rcs_sync #(.W(1), .RST_VAL(1'b1)) u_gsync (
    .clk (clk),
    .arst(!rst_n),
    .d   (peer_good),
    .q   (peer_good_s)
  );

  rcs_sync #(.W(1), .RST_VAL(1'b0)) u_esync (
    .clk (clk),
    .arst(!rst_n),
    .d   (peer_gate),
    .q   (peer_gate_s)
  );

  assign req = is_prim ? own_good : (!peer_good_s && !held);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stage1 <= 1'b0;
    else      stage1 <= req && !peer_gate_s;
  end

  always_ff @(negedge clk or posedge arst) begin
    if (arst) gate_en <= 1'b0;
    else      gate_en <= stage1;
  end

  // R4: the two gates are never open at once
  p_one_gate_r4: assert property (@(negedge clk) disable iff (!rst_n)
    gate_en |-> !peer_gate);

  // R3: a lane whose clock is declared lost has its gate and readiness dropped
  p_loss_shut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    self_lost |-> (!gate_en && !own_good));

  // R6: a held lane restarts its run count from zero
  p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (run_cnt == '0));

  // R5: a primary gate is only being armed after a full clean run
  p_holdoff_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (is_prim && stage1) |-> (run_cnt == FULL));
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover #(
  parameter int unsigned HOLD_CYC = 1024,
  parameter int unsigned LOSS_CYC = 4
) (
  input  logic clk_cmos,
  input  logic clk_xo,
  input  logic prim_sel,
  input  logic rst_n,
  output logic clk_out,
  output logic active_sel
);
  import rcs_pkg::*;

  logic [NUM_SRC-1:0] clk_v;
  logic [NUM_SRC-1:0] tog;
  logic [NUM_SRC-1:0] lost_seen;
  logic [NUM_SRC-1:0] good;
  logic [NUM_SRC-1:0] gate;

  assign clk_v[SRC_CMOS] = clk_cmos;
  assign clk_v[SRC_XO]   = clk_xo;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_lane
    localparam int PEER = NUM_SRC - 1 - gi;
    rcs_lane #(.HOLD_CYC(HOLD_CYC), .LOSS_CYC(LOSS_CYC)) u_lane (
      .clk      (clk_v[gi]),
      .rst_n    (rst_n),
      .is_prim  (prim_sel == 1'(gi)),
      .peer_tog (tog[PEER]),
      .self_lost(lost_seen[PEER]),
      .peer_good(good[PEER]),
      .peer_gate(gate[PEER]),
      .own_tog  (tog[gi]),
      .peer_lost(lost_seen[gi]),
      .own_good (good[gi]),
      .gate_en  (gate[gi])
    );
  end

  assign clk_out    = |(clk_v & gate);
  assign active_sel = gate[SRC_XO];
endmodule

// File: tb/refclk_failover_test.sv
`timescale 1ns/1ps
module refclk_failover_test;
  logic clk_cmos = 1'b0;
  logic clk_xo   = 1'b0;
  logic tb_clk   = 1'b0;
  logic prim_sel = 1'b1;
  logic rst_n    = 1'b0;
  logic clk_out;
  logic active_sel;
  bit   run_c = 1'b1;
  bit   run_x = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int n_c = 0, n_x = 0, n_o = 0;
  int narrow = 0;
  int model_n = 0, model_bad = 0;
  bit exp_on = 1'b0;
  bit exp_src = 1'b0;
  bit done = 1'b0;
  realtime t_edge = 0.0;

  refclk_failover uut (
    .clk_cmos  (clk_cmos),
    .clk_xo    (clk_xo),
    .prim_sel  (prim_sel),
    .rst_n     (rst_n),
    .clk_out   (clk_out),
    .active_sel(active_sel)
  );

  // 250 MHz bench clock drives the CMOS input; oscillator input slightly slower
  initial forever begin #2.0;  if (run_c) clk_cmos = ~clk_cmos; end
  initial forever begin #2.35; if (run_x) clk_xo   = ~clk_xo;   end
  initial begin #0.77; forever #2.0 tb_clk = ~tb_clk; end

  always @(posedge clk_cmos) n_c++;
  always @(posedge clk_xo)   n_x++;
  always @(posedge clk_out)  n_o++;

  // R4: phase-width monitor on the output
  always @(clk_out) begin
    if (rst_n && t_edge > 0.0 && ($realtime - t_edge) < 1.9) narrow++;
    t_edge = $realtime;
  end

  // R8: reference model of the expected source, compared each bench cycle
  always @(posedge tb_clk) begin
    if (rst_n && exp_on) begin
      model_n++;
      if (active_sel !== exp_src) model_bad++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge tb_clk);
  endtask

  task automatic wait_x(input int n);
    int base = n_x;
    while (n_x - base < n) @(posedge clk_xo);
  endtask

  task automatic wait_c(input int n);
    int base = n_c;
    while (n_c - base < n) @(posedge clk_cmos);
  endtask

  task automatic do_reset(input bit sel);
    exp_on = 1'b0;
    rst_n = 1'b0;
    prim_sel = sel;
    run_c = 1'b1;
    run_x = 1'b1;
    ticks(8);
    check(clk_out === 1'b0, "R1 clk_out low in reset", int'(clk_out), 0);
    check(active_sel === 1'b0, "R1 active_sel low in reset", int'(active_sel), 0);
    rst_n = 1'b1;
  endtask

  task automatic freq_check(input bit src, input string tag);
    int bo = n_o;
    int bs = src ? n_x : n_c;
    int d_o, d_s;
    ticks(40);
    d_o = n_o - bo;
    d_s = (src ? n_x : n_c) - bs;
    check((d_o - d_s <= 1) && (d_s - d_o <= 1), tag, d_o, d_s);
  endtask

  task automatic settle_to(input bit src);
    exp_src = src;
    exp_on = 1'b1;
  endtask

  initial begin
    // ---------------- oscillator primary ----------------
    do_reset(1'b1);
    ticks(20);
    check(active_sel === 1'b1, "R2 xo primary selected", int'(active_sel), 1);
    settle_to(1'b1);
    freq_check(1'b1, "R2 output follows xo edges");

    // R3: primary stops high
    @(posedge clk_xo); run_x = 1'b0; exp_on = 1'b0;
    ticks(20);
    check(active_sel === 1'b0, "R3 failover after xo stuck high", int'(active_sel), 0);
    settle_to(1'b0);
    freq_check(1'b0, "R3 output follows cmos after failover");

    // R5: holdoff on return
    exp_on = 1'b0;
    run_x = 1'b1;
    wait_x(1000);
    check(active_sel === 1'b0, "R5 still on standby at 1000 cycles", int'(active_sel), 0);
    wait_x(60);
    check(active_sel === 1'b1, "R5 back on primary by 1060 cycles", int'(active_sel), 1);
    settle_to(1'b1);
    ticks(10);

    // R6: primary stops low, returns, drops mid-holdoff, returns again
    @(negedge clk_xo); run_x = 1'b0; exp_on = 1'b0;
    ticks(20);
    check(active_sel === 1'b0, "R3 failover after xo stuck low", int'(active_sel), 0);
    run_x = 1'b1;
    wait_x(600);
    @(negedge clk_xo); run_x = 1'b0;
    ticks(20);
    check(active_sel === 1'b0, "R6 standby kept after second loss", int'(active_sel), 0);
    run_x = 1'b1;
    wait_x(900);
    check(active_sel === 1'b0, "R6 count restarted, no early return", int'(active_sel), 0);
    wait_x(160);
    check(active_sel === 1'b1, "R6 return after full clean run", int'(active_sel), 1);
    settle_to(1'b1);

    // R7: standby lost while primary in use
    @(posedge clk_cmos); run_c = 1'b0;
    ticks(30);
    check(active_sel === 1'b1, "R7 standby loss ignored", int'(active_sel), 1);
    freq_check(1'b1, "R7 output edges unchanged");
    run_c = 1'b1;
    ticks(10);

    // ---------------- CMOS primary ----------------
    do_reset(1'b0);
    ticks(20);
    check(active_sel === 1'b0, "R2 cmos primary selected", int'(active_sel), 0);
    settle_to(1'b0);
    freq_check(1'b0, "R2 output follows cmos edges");
    @(negedge clk_cmos); run_c = 1'b0; exp_on = 1'b0;
    ticks(20);
    check(active_sel === 1'b1, "R3 failover after cmos stuck low", int'(active_sel), 1);
    settle_to(1'b1);
    freq_check(1'b1, "R3 output follows xo after failover");
    exp_on = 1'b0;
    run_c = 1'b1;
    wait_c(1000);
    check(active_sel === 1'b1, "R5 cmos holdoff respected", int'(active_sel), 1);
    wait_c(60);
    check(active_sel === 1'b0, "R5 back on cmos primary", int'(active_sel), 0);
    settle_to(1'b0);
    ticks(20);

    check(narrow == 0, "R4 no short phase on clk_out", narrow, 0);
    check(model_bad == 0 && model_n > 0, "R8 active_sel matches model", model_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tb_clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule